// File: doc/BRIEF.md
# Mesh Turn Legality Checker

This block sits beside the route-computation stage of a router in a two-dimensional mesh. For each candidate hop it reports whether the packet may leave on the requested output direction, given the direction it is already travelling. Each deadlock-avoidance turn model works by forbidding a particular set of turns. With enough turns forbidden, no cycle of turns can close, so the packets waiting in a full set of buffers can never form a circular wait.

A two-bit mode input picks one of four turn models at run time: dimension-ordered XY, west-first, north-last and negative-first. The check is purely combinational: `turnLegal` follows the inputs with no clock and no stored state. Local injection, ejection, straight travel, reversal and malformed direction codes are each handled by a fixed rule that does not depend on the mode. Only true 90-degree turns are judged by the selected model.

Top module: `turn_check_top`

## Requirements
- R1: A direction code above 4 on either `inDir` or `outDir` gives `turnLegal`=0, whatever the other inputs are. The valid codes are LOCAL=0, EAST=1, WEST=2, NORTH=3, SOUTH=4.
- R2: With both codes valid, `outDir`=LOCAL (ejection) gives `turnLegal`=1 in every mode.
- R3: With both codes valid, `inDir`=LOCAL (injection) gives `turnLegal`=1 for every output and every mode.
- R4: Carrying on in the travel direction (`outDir` equal to a non-local `inDir`) gives `turnLegal`=1 in every mode.
- R5: A reversal (EAST to WEST, WEST to EAST, NORTH to SOUTH or SOUTH to NORTH) gives `turnLegal`=0 in every mode.
- R6: With `modeSel`=0 (XY), a turn from NORTH or SOUTH travel into EAST or WEST gives `turnLegal`=0.
- R7: With `modeSel`=1 (west-first), a turn into WEST gives `turnLegal`=0.
- R8: With `modeSel`=2 (north-last), any turn out of NORTH travel gives `turnLegal`=0.
- R9: With `modeSel`=3 (negative-first), a turn from positive travel (EAST or NORTH) into a negative direction (WEST or SOUTH) gives `turnLegal`=0. A turn between the two negative directions stays legal.
- R10: A 90-degree turn that the selected mode does not forbid gives `turnLegal`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| inDir | input | 3 | Current travel direction; LOCAL when the packet is being injected |
| outDir | input | 3 | Requested output direction |
| modeSel | input | 2 | Turn model: 0 XY, 1 west-first, 2 north-last, 3 negative-first |
| turnLegal | output | 1 | 1 when the requested hop is permitted |

## Verification
The bench drives every combination of the two 3-bit direction codes under all four modes. This covers the three unused codes on each side and so separates the malformed-code rule from everything else. Within the valid codes, it tells apart the mode-independent cases (injection, ejection, straight travel, reversal) from the 90-degree turns. For the turns, comparing the same turn across the four modes shows whether each model forbids exactly its own set. This matters most where the models disagree, such as a turn between the two negative directions, or a turn out of northward travel. The expected result comes from unit direction vectors: a reversal is a pair of vectors that sums to zero, and a direction's sign is the sum of its two components.

// File: rtl/turn_pkg.sv
package turn_pkg;
  localparam int DIR_W     = 3;
  localparam int MODE_W    = 2;
  localparam int NUM_MODES = 1 << MODE_W;
  localparam int NUM_DIRS  = 5;

  typedef enum logic [DIR_W-1:0] {
    DIR_LOCAL = 3'd0,
    DIR_EAST  = 3'd1,
    DIR_WEST  = 3'd2,
    DIR_NORTH = 3'd3,
    DIR_SOUTH = 3'd4
  } dir_e;

  typedef enum logic [MODE_W-1:0] {
    MODE_XY     = 2'd0,
    MODE_WFIRST = 2'd1,
    MODE_NLAST  = 2'd2,
    MODE_NFIRST = 2'd3
  } mode_e;

  // Strobes from the classifier to the rule datapath
  typedef struct packed {
    logic badCode;
    logic ejectReq;
    logic fromLocal;
    logic goStraight;
    logic isReverse;
    logic inYAxis;
    logic outXAxis;
    logic outWest;
    logic inNorth;
    logic inPositive;
    logic outNegative;
  } turnStrobes_t;
endpackage

// File: rtl/turn_class_ctrl.sv
module turn_class_ctrl
  import turn_pkg::*;
(
  input  logic [DIR_W-1:0] inDir,
  input  logic [DIR_W-1:0] outDir,
  output turnStrobes_t     strobes
);
  function automatic logic validCode(input logic [DIR_W-1:0] code);
    return code < DIR_W'(NUM_DIRS);
  endfunction

  function automatic logic [DIR_W-1:0] opposite(input logic [DIR_W-1:0] code);
    case (code)
      DIR_EAST:  return DIR_WEST;
      DIR_WEST:  return DIR_EAST;
      DIR_NORTH: return DIR_SOUTH;
      DIR_SOUTH: return DIR_NORTH;
      default:   return DIR_LOCAL;
    endcase
  endfunction

  logic inValid, outValid, inMoving, outMoving;

  always_comb begin
    inValid   = validCode(inDir);
    outValid  = validCode(outDir);
    inMoving  = inValid  && (inDir  != DIR_LOCAL);
    outMoving = outValid && (outDir != DIR_LOCAL);

    strobes.badCode     = !(inValid && outValid);
    strobes.ejectReq    = outValid && (outDir == DIR_LOCAL);
    strobes.fromLocal   = inValid && (inDir == DIR_LOCAL);
    strobes.goStraight  = inMoving && (outDir == inDir);
    strobes.isReverse   = inMoving && outMoving && (outDir == opposite(inDir));
    strobes.inYAxis     = (inDir == DIR_NORTH) || (inDir == DIR_SOUTH);
    strobes.outXAxis    = (outDir == DIR_EAST) || (outDir == DIR_WEST);
    strobes.outWest     = (outDir == DIR_WEST);
    strobes.inNorth     = (inDir == DIR_NORTH);
    strobes.inPositive  = (inDir == DIR_EAST) || (inDir == DIR_NORTH);
    strobes.outNegative = (outDir == DIR_WEST) || (outDir == DIR_SOUTH);
  end
endmodule

// File: rtl/turn_rule_dp.sv
module turn_rule_dp
  import turn_pkg::*;
(
  input  turnStrobes_t      strobes,
  input  logic [MODE_W-1:0] modeSel,
  output logic              turnLegal
);
  logic [NUM_MODES-1:0] forbidByMode;

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    if (m == int'(MODE_XY)) begin : g_xy
      assign forbidByMode[m] = strobes.inYAxis && strobes.outXAxis;
    end else if (m == int'(MODE_WFIRST)) begin : g_wf
      assign forbidByMode[m] = strobes.outWest;
    end else if (m == int'(MODE_NLAST)) begin : g_nl
      assign forbidByMode[m] = strobes.inNorth;
    end else begin : g_nf
      assign forbidByMode[m] = strobes.inPositive && strobes.outNegative;
    end
  end

  logic turnForbid, fixedPass;

  always_comb begin
    turnForbid = forbidByMode[modeSel];
    fixedPass  = strobes.ejectReq || strobes.fromLocal || strobes.goStraight;
    turnLegal  = !strobes.badCode &&
                 (fixedPass || (!strobes.isReverse && !turnForbid));
  end
endmodule

// File: rtl/turn_check_top.sv
module turn_check_top
  import turn_pkg::*;
(
  input  logic [2:0] inDir,
  input  logic [2:0] outDir,
  input  logic [1:0] modeSel,
  output logic       turnLegal
);
  turnStrobes_t strobes;

  turn_class_ctrl ctrl_i (
    .inDir   (inDir),
    .outDir  (outDir),
    .strobes (strobes)
  );

  turn_rule_dp dp_i (
    .strobes   (strobes),
    .modeSel   (modeSel),
    .turnLegal (turnLegal)
  );
endmodule

// File: rtl/turn_check_sva.sv
module turn_check_sva (
  input logic [2:0] inDir,
  input logic [2:0] outDir,
  input logic [1:0] modeSel,
  input logic       turnLegal
);
  logic okCodes, inMov, outMov, turn90, rev;

  always_comb begin
    okCodes = (inDir <= 3'd4) && (outDir <= 3'd4);
    inMov   = okCodes && (inDir != 3'd0);
    outMov  = okCodes && (outDir != 3'd0);
    rev     = inMov && outMov && ({inDir, outDir} inside {6'o12, 6'o21, 6'o34, 6'o43});
    turn90  = inMov && outMov && (inDir != outDir) && !rev;

    // R1
    bad_code_chk: assert (okCodes || !turnLegal);
    // R2
    eject_ok_chk: assert (!(okCodes && outDir == 3'd0) || turnLegal);
    // R3
    inject_ok_chk: assert (!(okCodes && inDir == 3'd0) || turnLegal);
    // R4
    straight_ok_chk: assert (!(inMov && outDir == inDir) || turnLegal);
    // R5
    reverse_block_chk: assert (!rev || !turnLegal);
    // R6
    xy_block_chk: assert (!(turn90 && modeSel == 2'd0 && inDir >= 3'd3) || !turnLegal);
    // R7
    wfirst_block_chk: assert (!(turn90 && modeSel == 2'd1 && outDir == 3'd2) || !turnLegal);
    // R8
    nlast_block_chk: assert (!(turn90 && modeSel == 2'd2 && inDir == 3'd3) || !turnLegal);
    // R9
    nfirst_block_chk: assert (!(turn90 && modeSel == 2'd3 && (inDir == 3'd1 || inDir == 3'd3)
                                && (outDir == 3'd2 || outDir == 3'd4)) || !turnLegal);
  end
endmodule

bind turn_check_top turn_check_sva sva_i (
  .inDir     (inDir),
  .outDir    (outDir),
  .modeSel   (modeSel),
  .turnLegal (turnLegal)
);

// File: tb/turn_check_top_tb.sv
`timescale 1ns/1ps
module turn_check_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [2:0] inDir, outDir;
  logic [1:0] modeSel;
  logic       turnLegal;
  int checks = 0, fails = 0;
  bit done = 0;

  turn_check_top dut_i (
    .inDir(inDir), .outDir(outDir), .modeSel(modeSel), .turnLegal(turnLegal)
  );

  // unit vector of a direction code: LOCAL=0 E=1 W=2 N=3 S=4
  function automatic void vec(input int code, output int dx, output int dy);
    dx = (code == 1) ? 1 : (code == 2) ? -1 : 0;
    dy = (code == 3) ? 1 : (code == 4) ? -1 : 0;
  endfunction

  function automatic void expect_of(input int di, input int dO, input int md,
                                    output bit ok, output string tag);
    int ix, iy, ox, oy;
    vec(di, ix, iy);
    vec(dO, ox, oy);
    if (di > 4 || dO > 4)      begin ok = 0; tag = "R1"; end
    else if (dO == 0)          begin ok = 1; tag = "R2"; end
    else if (di == 0)          begin ok = 1; tag = "R3"; end
    else if (di == dO)         begin ok = 1; tag = "R4"; end
    else if (ix + ox == 0 && iy + oy == 0) begin ok = 0; tag = "R5"; end
    else begin
      bit forbid;
      case (md)
        0: begin forbid = (ix == 0) && (oy == 0); tag = "R6"; end
        1: begin forbid = (ox == -1);             tag = "R7"; end
        2: begin forbid = (iy == 1);              tag = "R8"; end
        default: begin forbid = (ix + iy > 0) && (ox + oy < 0); tag = "R9"; end
      endcase
      if (!forbid) tag = "R10";
      ok = !forbid;
    end
  endfunction

  task automatic check(input bit exp, input string tag);
    checks++;
    if (turnLegal !== exp) begin
      fails++;
      $display("FAIL %s in=%0d out=%0d mode=%0d actual=%b expected=%b",
               tag, inDir, outDir, modeSel, turnLegal, exp);
    end
  endtask

  initial begin
    inDir = 3'd0; outDir = 3'd0; modeSel = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1'b1, "R2 reset-time local/local");
    rst = 1'b0;
    for (int md = 0; md < 4; md++) begin
      for (int di = 0; di < 8; di++) begin
        for (int dO = 0; dO < 8; dO++) begin
          bit ok;
          string tag;
          @(posedge clk);
          inDir = 3'(di); outDir = 3'(dO); modeSel = 2'(md);
          @(negedge clk);
          expect_of(di, dO, md, ok, tag);
          check(ok, tag);
        end
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule